// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes three stereo serial audio lines that share one bit clock and one channel clock and turns them into parallel 24-bit left and right words. The bit clock, channel clock and data lines are sampled in the system clock domain. Each rising edge of the bit clock, seen in the registered samples, is one serial bit. A 2-bit mode input picks right-justified, left-justified or I2S framing. A 2-bit resolution input picks 24, 20, 18 or 16 bits per word. The block measures how many bits each half-frame holds, which tells 24-bit slots from 32-bit slots. Right-justified words are placed from that measured length.

Results leave through a valid/ready port as one stereo pair per frame for all three lines together. A completed pair loads into the output register when the register is empty or is being emptied in the same cycle. The serial side cannot be stalled, so a pair that completes while the previous one is still waiting is discarded. The waiting pair stays unchanged until `pair_ready` is seen high.

Top module: `aurx_receiver`

## Requirements
- R1: Mode encoding is 00 right-justified, 01 I2S and 10 left-justified. Mode 11 is invalid and produces no output pairs.
- R2: In left-justified mode the MSB is the first bit of a half-frame, and `sf` high marks the left channel.
- R3: In I2S mode the MSB is the second bit of a half-frame, and `sf` low marks the left channel. With 24-bit slots a 24-bit word ends on the first bit of the next half-frame.
- R4: In right-justified mode the LSB is the last bit before the `sf` transition, and `sf` high marks the left channel. The word starts at bit (slot length minus resolution) of the half-frame.
- R5: The slot length is measured from the previous complete half-frame: 28 or more bits count as 32, otherwise 24. Bits before the first `sf` transition after reset are ignored, and until the first measurement the length is taken as 32.
- R6: Resolution encoding is 00 24-bit, 01 20-bit, 10 18-bit and 11 16-bit. Each word is presented left-aligned at bit 23, with its unused LSBs zero.
- R7: All three lines use the same framing. Each line's words appear at its own 24-bit field, with line k at bits [24k+23:24k].
- R8: A pair is offered once the right word of a frame that also had a left word completes. While `pair_valid` is high and `pair_ready` is low, the pair and the valid stay unchanged.
- R9: A pair completing while the held pair has not been accepted is discarded, and the held pair is kept.
- R10: After reset `pair_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sc | input | 1 | Serial bit clock, sampled |
| sf | input | 1 | Channel clock, sampled |
| sd | input | LANES | Serial data lines |
| frame_mode | input | 2 | Framing select (R1) |
| word_res | input | 2 | Resolution select (R6) |
| pair_valid | output | 1 | Output pair available |
| pair_ready | input | 1 | Consumer accepts pair |
| pair_left | output | LANES*24 | Left words, line k at [24k+23:24k] |
| pair_right | output | LANES*24 | Right words, same layout |

## Verification
The embedded assertions check on every cycle that a held pair stays valid and unchanged under back-pressure. They also check that load and shift never coincide, that an invalid mode produces no pair, and that a finished word has zero LSBs below its resolution. The correct bit placement for each framing, the slot-length detection, the per-line data and the discarding of a pair under back-pressure can only be seen through the bench's scenarios. Those scenarios sweep every mode, slot length and resolution, and compare the words against values computed arithmetically.

// File: rtl/aurx_pkg.sv
package aurx_pkg;
  localparam int WORD_W = 24;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int POS_W  = 6;

  typedef enum logic [1:0] {
    FMT_RIGHT = 2'b00,
    FMT_I2S   = 2'b01,
    FMT_LEFT  = 2'b10,
    FMT_BAD   = 2'b11
  } frame_mode_e;

  function automatic logic [CNT_W-1:0] res_bits(input logic [1:0] r);
    case (r)
      2'b00:   res_bits = CNT_W'(24);
      2'b01:   res_bits = CNT_W'(20);
      2'b10:   res_bits = CNT_W'(18);
      default: res_bits = CNT_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/aurx_frame_ctl.sv
module aurx_frame_ctl
  import aurx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sc_i,
  input  logic             sf_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       res_i,
  output logic             load_o,
  output logic             shift_o,
  output logic             done_left_o,
  output logic             done_right_o,
  output logic [CNT_W-1:0] wlen_o,
  output logic             pair_o
);
  logic             sc_q, sc_qq, sf_q, sf_last, seen, synced, slot32;
  logic             active, tag_left, have_left, pair_q;
  logic [POS_W-1:0] pos;
  logic [CNT_W-1:0] cnt, wlen_q;

  logic             rise, mode_ok, edge_hit, synced_n, slot32_n, chan_left;
  logic             start, step, fin;
  logic [POS_W-1:0] pos_n, slot_len, start_pos;
  logic [CNT_W-1:0] wsel;

  always_comb begin
    rise      = sc_q & ~sc_qq;
    mode_ok   = (mode_i != FMT_BAD);
    edge_hit  = seen && (sf_q != sf_last);
    pos_n     = edge_hit ? '0 : ((pos == '1) ? pos : pos + POS_W'(1));
    synced_n  = synced | edge_hit;
    slot32_n  = (edge_hit && synced) ? (pos >= POS_W'(27)) : slot32;
    wsel      = res_bits(res_i);
    slot_len  = slot32_n ? POS_W'(32) : POS_W'(24);
    case (mode_i)
      FMT_LEFT:  start_pos = '0;
      FMT_I2S:   start_pos = POS_W'(1);
      FMT_RIGHT: start_pos = slot_len - POS_W'(wsel);
      default:   start_pos = '1;
    endcase
    chan_left = (mode_i == FMT_I2S) ? ~sf_q : sf_q;
    start     = rise && synced_n && mode_ok && (pos_n == start_pos);
    step      = rise && active && !start && mode_ok;
    fin       = step && ((cnt + CNT_W'(1)) == wlen_q);
  end

  assign load_o       = start;
  assign shift_o      = step;
  assign done_left_o  = fin && tag_left;
  assign done_right_o = fin && !tag_left;
  assign wlen_o       = wlen_q;
  assign pair_o       = pair_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc_q <= 1'b0; sc_qq <= 1'b0; sf_q <= 1'b0;
      sf_last <= 1'b0; seen <= 1'b0; synced <= 1'b0; slot32 <= 1'b1;
      pos <= '0; active <= 1'b0; cnt <= '0; tag_left <= 1'b0;
      wlen_q <= CNT_W'(WORD_W); have_left <= 1'b0; pair_q <= 1'b0;
    end else begin
      sc_q  <= sc_i;
      sc_qq <= sc_q;
      sf_q  <= sf_i;
      if (rise) begin
        sf_last <= sf_q;
        seen    <= 1'b1;
        pos     <= pos_n;
        synced  <= synced_n;
        slot32  <= slot32_n;
      end
      if (!mode_ok) begin
        active <= 1'b0;
      end else if (start) begin
        active   <= 1'b1;
        cnt      <= CNT_W'(1);
        tag_left <= chan_left;
        wlen_q   <= wsel;
      end else if (step) begin
        cnt <= cnt + CNT_W'(1);
        if (fin) active <= 1'b0;
      end
      if (!mode_ok)          have_left <= 1'b0;
      else if (done_left_o)  have_left <= 1'b1;
      else if (done_right_o) have_left <= 1'b0;
      pair_q <= done_right_o && have_left;
    end
  end

  assert_single_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_o, shift_o}));

  assert_no_pair_bad_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == FMT_BAD) |=> !pair_o);

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt < wlen_q));
endmodule

// File: rtl/aurx_lane.sv
module aurx_lane
  import aurx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sd_i,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              done_left_i,
  input  logic              done_right_i,
  input  logic [CNT_W-1:0]  wlen_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o
);
  logic              sd_q;
  logic [WORD_W-1:0] sh, nxt, aligned, lo_mask;
  logic [CNT_W-1:0]  pad;

  always_comb begin
    nxt     = {sh[WORD_W-2:0], sd_q};
    pad     = CNT_W'(WORD_W) - wlen_i;
    aligned = nxt << pad;
    lo_mask = ~({WORD_W{1'b1}} << pad);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sd_q <= 1'b0; sh <= '0; left_o <= '0; right_o <= '0;
    end else begin
      sd_q <= sd_i;
      if (load_i)       sh <= {{(WORD_W-1){1'b0}}, sd_q};
      else if (shift_i) sh <= nxt;
      if (done_left_i)  left_o  <= aligned;
      if (done_right_i) right_o <= aligned;
    end
  end

  assert_left_lsb_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_left_i |=> ((left_o & $past(lo_mask)) == '0));

  assert_right_lsb_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_right_i |=> ((right_o & $past(lo_mask)) == '0));
endmodule

// File: rtl/aurx_outbuf.sv
module aurx_outbuf
  import aurx_pkg::*;
#(
  parameter int LANES = 3,
  localparam int BUS_W = LANES * WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pair_i,
  input  logic [BUS_W-1:0] left_i,
  input  logic [BUS_W-1:0] right_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [BUS_W-1:0] left_o,
  output logic [BUS_W-1:0] right_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0; left_o <= '0; right_o <= '0;
    end else if (pair_i && (!valid_o || ready_i)) begin
      valid_o <= 1'b1;
      left_o  <= left_i;
      right_o <= right_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  assert_hold_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> valid_o);

  assert_hold_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> ($stable(left_o) && $stable(right_o)));
endmodule

// File: rtl/aurx_receiver.sv
module aurx_receiver
  import aurx_pkg::*;
#(
  parameter int LANES = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sc,
  input  logic                    sf,
  input  logic [LANES-1:0]        sd,
  input  logic [1:0]              frame_mode,
  input  logic [1:0]              word_res,
  output logic                    pair_valid,
  input  logic                    pair_ready,
  output logic [LANES*WORD_W-1:0] pair_left,
  output logic [LANES*WORD_W-1:0] pair_right
);
  localparam int BUS_W = LANES * WORD_W;

  logic             load, shift, done_l, done_r, pair;
  logic [CNT_W-1:0] wlen;
  logic [BUS_W-1:0] lane_left, lane_right;

  aurx_frame_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .sc_i(sc), .sf_i(sf),
    .mode_i(frame_mode), .res_i(word_res),
    .load_o(load), .shift_o(shift),
    .done_left_o(done_l), .done_right_o(done_r),
    .wlen_o(wlen), .pair_o(pair)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    aurx_lane u_lane (
      .clk(clk), .rst_n(rst_n), .sd_i(sd[k]),
      .load_i(load), .shift_i(shift),
      .done_left_i(done_l), .done_right_i(done_r), .wlen_i(wlen),
      .left_o(lane_left[k*WORD_W +: WORD_W]),
      .right_o(lane_right[k*WORD_W +: WORD_W])
    );
  end

  aurx_outbuf #(.LANES(LANES)) u_out (
    .clk(clk), .rst_n(rst_n), .pair_i(pair),
    .left_i(lane_left), .right_i(lane_right), .ready_i(pair_ready),
    .valid_o(pair_valid), .left_o(pair_left), .right_o(pair_right)
  );
endmodule

// File: tb/sim_aurx_receiver.sv
module sim_aurx_receiver;
  localparam int LANES = 3;
  localparam int BW = LANES * 24;

  logic clk = 1'b0, rst_n = 1'b0, sc = 1'b0, sf = 1'b0, pair_ready = 1'b1;
  logic [LANES-1:0] sd = '0;
  logic [1:0] frame_mode = 2'b10, word_res = 2'b00;
  logic pair_valid;
  logic [BW-1:0] pair_left, pair_right;

  aurx_receiver #(.LANES(LANES)) u0 (
    .clk(clk), .rst_n(rst_n), .sc(sc), .sf(sf), .sd(sd),
    .frame_mode(frame_mode), .word_res(word_res),
    .pair_valid(pair_valid), .pair_ready(pair_ready),
    .pair_left(pair_left), .pair_right(pair_right)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, rx_n = 0;
  logic [BW-1:0] rx_l [0:15];
  logic [BW-1:0] rx_r [0:15];
  logic [BW-1:0] ex_l [0:7];
  logic [BW-1:0] ex_r [0:7];
  bit st_sf [0:599];
  bit [LANES-1:0] st_sd [0:599];
  logic [31:0] seed = 32'h1234_5678;

  always @(negedge clk)
    if (rst_n && pair_valid && pair_ready) begin
      if (rx_n < 16) begin rx_l[rx_n] = pair_left; rx_r[rx_n] = pair_right; end
      rx_n = rx_n + 1;
    end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sc = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    rx_n = 0;
    @(negedge clk);
  endtask

  task automatic send_bit(input bit sfv, input bit [LANES-1:0] d);
    @(negedge clk);
    sf = sfv; sd = d;
    repeat (2) @(negedge clk);
    sc = 1'b1;
    repeat (3) @(negedge clk);
    sc = 1'b0;
  endtask

  function automatic int wbits(input logic [1:0] r);
    case (r) 2'b00: return 24; 2'b01: return 20; 2'b10: return 18; default: return 16; endcase
  endfunction

  // Builds and sends nfr frames; when chk_on, compares the last nfr-1 pairs
  task automatic run_cfg(input logic [1:0] m, input logic [1:0] r, input int slot, input int nfr, input bit chk_on);
    int w, pre, st, total;
    bit lft;
    string tag;
    w = wbits(r);
    lft = (m == 2'b01) ? 1'b0 : 1'b1;
    pre = 3;
    st = (m == 2'b10) ? 0 : (m == 2'b01) ? 1 : slot - w;
    total = pre + nfr * 2 * slot + 4;
    for (int i = 0; i < 600; i++) begin st_sf[i] = 0; st_sd[i] = '0; end
    for (int i = 0; i < pre; i++) st_sf[i] = ~lft;
    for (int f = 0; f < nfr; f++)
      for (int h = 0; h < 2; h++) begin
        int hb;
        hb = pre + (2 * f + h) * slot;
        for (int p = 0; p < slot; p++) st_sf[hb + p] = (h == 0) ? lft : ~lft;
        for (int ln = 0; ln < LANES; ln++) begin
          logic [23:0] word;
          seed = seed * 32'd1103515245 + 32'd12345;
          word = seed[31:8] & ((24'h1 << w) - 24'h1);
          for (int b = 0; b < w; b++) st_sd[hb + st + b][ln] = word[w - 1 - b];
          if (f < 8) begin
            if (h == 0) ex_l[f][ln*24 +: 24] = word << (24 - w);
            else        ex_r[f][ln*24 +: 24] = word << (24 - w);
          end
        end
      end
    for (int i = total - 4; i < total; i++) st_sf[i] = lft;
    frame_mode = m; word_res = r;
    do_reset();
    for (int i = 0; i < total; i++) send_bit(st_sf[i], st_sd[i]);
    repeat (20) @(negedge clk);
    if (chk_on) begin
      tag = (m == 2'b00) ? "R4/R5/R6/R7" : (m == 2'b01) ? "R3/R6/R7" : "R2/R6/R7";
      chk(rx_n >= nfr - 1 && rx_n <= nfr, {tag, "/R8 pair count"}, BW'(rx_n), BW'(nfr));
      if (rx_n >= nfr - 1 && rx_n <= nfr)
        for (int k = 0; k < nfr - 1; k++) begin
          int o;
          o = rx_n - (nfr - 1) + k;
          for (int ln = 0; ln < LANES; ln++) begin
            chk(rx_l[o][ln*24 +: 24] == ex_l[k+1][ln*24 +: 24], {tag, " left"},
                BW'(rx_l[o][ln*24 +: 24]), BW'(ex_l[k+1][ln*24 +: 24]));
            chk(rx_r[o][ln*24 +: 24] == ex_r[k+1][ln*24 +: 24], {tag, " right"},
                BW'(rx_r[o][ln*24 +: 24]), BW'(ex_r[k+1][ln*24 +: 24]));
          end
        end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [BW-1:0] hold_l, hold_r;
    do_reset();
    chk(pair_valid == 1'b0, "R10 reset valid", BW'(pair_valid), '0);

    for (int m = 0; m < 3; m++)
      for (int s = 0; s < 2; s++)
        for (int r = 0; r < 4; r++)
          run_cfg(2'(m), 2'(r), (s == 0) ? 24 : 32, 4, 1'b1);

    // R1: invalid mode never yields a pair
    run_cfg(2'b11, 2'b00, 32, 4, 1'b0);
    chk(rx_n == 0, "R1 invalid mode pairs", BW'(rx_n), '0);
    chk(pair_valid == 1'b0, "R1 invalid mode valid", BW'(pair_valid), '0);

    // R8/R9: back-pressure holds the first pair, later pairs dropped
    pair_ready = 1'b0;
    run_cfg(2'b10, 2'b00, 32, 3, 1'b0);
    chk(pair_valid == 1'b1, "R8 held valid", BW'(pair_valid), BW'(1));
    chk(pair_left == ex_l[0], "R9 held left", pair_left, ex_l[0]);
    chk(pair_right == ex_r[0], "R9 held right", pair_right, ex_r[0]);
    hold_l = pair_left; hold_r = pair_right;
    repeat (10) @(negedge clk);
    chk(pair_left == hold_l && pair_right == hold_r && pair_valid, "R8 stable under stall",
        pair_left, hold_l);
    @(posedge clk); #1 pair_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(pair_valid == 1'b0, "R8 drained after accept", BW'(pair_valid), '0);

    summary();
  end
endmodule